// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is a bus master for a shared address/data bus. A client hands it one transfer at a time: an address, a direction, a memory-or-I/O flag and, for writes, a data word. The sequencer then runs a bus cycle made of fixed phases. The first phase is T1, in which the address is on the shared lines and the latch strobe is high. T2 follows, and in it the read or write strobe and the data enable become active. T3 is the phase in which read data is sampled. T4 releases every control strobe. Wait phases are inserted after T2 for as long as the responder holds its ready input low.

The shared bus is modelled as three signals. The first is a driven value. The second is an output enable, which is low whenever the responder owns the lines. The third is a sampled input that carries read data. The read strobe, the write strobe and the data enable are active low. The address latch strobe is active high. The direction output reads 0 for a read and 1 for a write. A one-cycle done pulse in T4 marks the end of each transfer, and the captured read data is valid in that cycle. A new request can be taken in the same T4 cycle, so bus cycles can follow one another with no idle gap.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset, and in every idle cycle, `rd_n`, `wr_n` and `den_n` are 1, while `ale`, `ad_oe`, `done`, `dtr` and `mio` are 0 and `req_ready` is 1.
- R2: In the cycle after a request is accepted (T1), `ale` is 1, `ad_oe` is 1, `ad_out` equals the request address, and `rd_n`, `wr_n` and `den_n` stay 1.
- R3: In T2, `ale` is 0 and `den_n` is 0. A read drives `rd_n` to 0 and keeps `wr_n` at 1; a write drives `wr_n` to 0 and keeps `rd_n` at 1. On a write, `ad_oe` is 1 and `ad_out` carries the write data in bits [DATA_W-1:0] with zeros above them. On a read, `ad_oe` is 0.
- R4: `ready_in` is sampled at the clock edge that ends T2. If it is 1, T3 follows at once, so the cycle lasts exactly four clocks from T1 to T4.
- R5: If `ready_in` is 0 at the end of T2 or of a wait phase, a wait phase follows. In a wait phase every bus output equals its T2 value, and T3 begins one clock after `ready_in` is seen at 1. The cycle then lasts 4+N clocks for N wait phases.
- R6: On a read, `ad_in` is captured at the edge that ends T3 and appears on `rdata` in T4. `rdata` changes at no other time, so write cycles and `ad_in` values at any other point leave it unchanged.
- R7: In T4, `rd_n`, `wr_n` and `den_n` are 1, `ale` is 0 and `done` is 1. `done` lasts exactly one cycle per bus cycle. On a write, `ad_oe` stays 1 and `ad_out` still holds the write data. On a read, `ad_oe` is 0.
- R8: From T1 through T4, `dtr` equals the request direction (0 read, 1 write) and `mio` equals the request's I/O flag (1 I/O, 0 memory). These values come from the captured request and do not follow later changes on the request inputs.
- R9: `req_ready` is 1 only in idle and in T4. A `req_valid` pulse raised while `req_ready` is 0 is ignored. A request presented in T4 starts T1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| ready_in | input | 1 | Responder ready, sampled at end of T2 and of each wait |
| ad_out | output | ADDR_W | Value driven onto the shared lines |
| ad_oe | output | 1 | Shared-line output enable |
| ad_in | input | DATA_W | Sampled shared-line data |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data enable, active low |
| dtr | output | 1 | Direction, 1 transmit / 0 receive |
| mio | output | 1 | Space select, 1 I/O / 0 memory |
| done | output | 1 | One-cycle end-of-transfer pulse in T4 |
| rdata | output | DATA_W | Captured read data |

## Verification
Several properties are checked on every cycle. The read and write strobes are never both active. The latch strobe never overlaps a data strobe. Strobe polarity always agrees with the direction output. A low ready freezes every bus output into a wait phase. An accepted request always yields T1 with its own address. The done pulse is single and has every strobe released. Read data changes only with done. Other behaviour can be shown only by the bench's scenarios. These are the exact number of wait phases for a given ready pattern, the write data and zero extension seen on the bus, that the captured word is the value present at the end of T3 and not at some other time, and that a request raised mid-cycle has no effect while a request raised in T4 chains without an idle gap.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   typedef enum logic [2:0] {
      TS_IDLE = 3'd0,
      TS_T1   = 3'd1,
      TS_T2   = 3'd2,
      TS_TW   = 3'd3,
      TS_T3   = 3'd4,
      TS_T4   = 3'd5
   } tstate_e;

   // phases in which the data strobes and data enable are active
   function automatic logic strobe_phase(input tstate_e st);
      return (st == TS_T2) || (st == TS_TW) || (st == TS_T3);
   endfunction

   // phases in which a new request may be taken
   function automatic logic accept_phase(input tstate_e st);
      return (st == TS_IDLE) || (st == TS_T4);
   endfunction

endpackage

// File: rtl/mbs_tstate_fsm.sv
module mbs_tstate_fsm
   import mbs_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  logic    ready_in,
   output tstate_e cur_st
);

   tstate_e nxt_st;

   always_comb begin
      nxt_st = cur_st;
      case (cur_st)
         TS_IDLE: nxt_st = start ? TS_T1 : TS_IDLE;
         TS_T1:   nxt_st = TS_T2;
         TS_T2:   nxt_st = ready_in ? TS_T3 : TS_TW;
         TS_TW:   nxt_st = ready_in ? TS_T3 : TS_TW;
         TS_T3:   nxt_st = TS_T4;
         TS_T4:   nxt_st = start ? TS_T1 : TS_IDLE;
         default: nxt_st = TS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_st <= TS_IDLE;
      else        cur_st <= nxt_st;
   end

endmodule

// File: rtl/mbs_req_hold.sv
module mbs_req_hold #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              in_write,
   input  logic              in_io,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   output logic              h_write,
   output logic              h_io,
   output logic [ADDR_W-1:0] h_addr,
   output logic [DATA_W-1:0] h_wdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_write <= 1'b0;
         h_io    <= 1'b0;
         h_addr  <= '0;
         h_wdata <= '0;
      end else if (load) begin
         h_write <= in_write;
         h_io    <= in_io;
         h_addr  <= in_addr;
         h_wdata <= in_wdata;
      end
   end

endmodule

// File: rtl/mbs_bus_drive.sv
module mbs_bus_drive
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input  tstate_e           cur_st,
   input  logic              h_write,
   input  logic              h_io,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [ADDR_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              den_n,
   output logic              dtr,
   output logic              mio,
   output logic              done
);

   localparam int PAD_W = ADDR_W - DATA_W;

   logic [ADDR_W-1:0] wext;
   logic              in_cycle;
   logic              strobing;
   logic              data_phase;

   generate
      if (PAD_W == 0) begin : g_same_w
         assign wext = h_wdata;
      end else begin : g_pad_w
         assign wext = {{PAD_W{1'b0}}, h_wdata};
      end
   endgenerate

   assign in_cycle   = (cur_st != TS_IDLE);
   assign strobing   = strobe_phase(cur_st);
   // write data stays on the lines through T4, past the strobe's rising edge
   assign data_phase = strobing || (cur_st == TS_T4);

   always_comb begin
      ale    = (cur_st == TS_T1);
      rd_n   = !(strobing && !h_write);
      wr_n   = !(strobing && h_write);
      den_n  = !strobing;
      dtr    = in_cycle && h_write;
      mio    = in_cycle && h_io;
      done   = (cur_st == TS_T4);
      if (cur_st == TS_T1) begin
         ad_oe  = 1'b1;
         ad_out = h_addr;
      end else if (data_phase && h_write) begin
         ad_oe  = 1'b1;
         ad_out = wext;
      end else begin
         ad_oe  = 1'b0;
         ad_out = h_addr;
      end
   end

endmodule

// File: rtl/mbs_read_capture.sv
module mbs_read_capture
   import mbs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tstate_e           cur_st,
   input  logic              h_write,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] rdata
);

   logic take;
   assign take = (cur_st == TS_T3) && !h_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata <= '0;
      else if (take) rdata <= ad_in;
   end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ready_in,
   output logic [ADDR_W-1:0] ad_out,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_in,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              den_n,
   output logic              dtr,
   output logic              mio,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);

   initial begin
      if (DATA_W < 1 || DATA_W > ADDR_W)
         $error("mux_bus_seq: DATA_W must be in 1..ADDR_W");
   end

   tstate_e           cur_st;
   logic              start;
   logic              h_write;
   logic              h_io;
   logic [ADDR_W-1:0] h_addr;
   logic [DATA_W-1:0] h_wdata;

   assign req_ready = accept_phase(cur_st);
   assign start     = req_valid && req_ready;

   mbs_tstate_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ready_in (ready_in),
      .cur_st   (cur_st)
   );

   mbs_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .in_write (req_write),
      .in_io    (req_io),
      .in_addr  (req_addr),
      .in_wdata (req_wdata),
      .h_write  (h_write),
      .h_io     (h_io),
      .h_addr   (h_addr),
      .h_wdata  (h_wdata)
   );

   mbs_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
      .cur_st  (cur_st),
      .h_write (h_write),
      .h_io    (h_io),
      .h_addr  (h_addr),
      .h_wdata (h_wdata),
      .ad_out  (ad_out),
      .ad_oe   (ad_oe),
      .ale     (ale),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .den_n   (den_n),
      .dtr     (dtr),
      .mio     (mio),
      .done    (done)
   );

   mbs_read_capture #(.DATA_W(DATA_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur_st  (cur_st),
      .h_write (h_write),
      .ad_in   (ad_in),
      .rdata   (rdata)
   );

endmodule

// File: rtl/mbs_chk.sv
module mbs_chk
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input tstate_e           cur_st,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              ready_in,
   input logic [ADDR_W-1:0] ad_out,
   input logic              ad_oe,
   input logic              ale,
   input logic              rd_n,
   input logic              wr_n,
   input logic              den_n,
   input logic              dtr,
   input logic              done,
   input logic [DATA_W-1:0] rdata
);

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n)); // R3

   AST_ALE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wr_n && den_n && ad_oe)); // R2

   AST_ACCEPT_T1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (ale && ad_out == $past(req_addr))); // R9

   AST_READY_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      ((cur_st == TS_T2 || cur_st == TS_TW) && ready_in) |=> (cur_st == TS_T3)); // R4

   AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      ((cur_st == TS_T2 || cur_st == TS_TW) && !ready_in) |=>
         (cur_st == TS_TW && $stable(rd_n) && $stable(wr_n) && $stable(den_n)
          && $stable(ad_oe) && $stable(ad_out) && $stable(dtr))); // R5

   AST_RDATA_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata) |-> done); // R6

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rd_n && wr_n && den_n && !ale)); // R7

   AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ((!rd_n |-> !dtr) and (!wr_n |-> dtr))); // R8

endmodule

bind mux_bus_seq mbs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cur_st    (cur_st),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .ready_in  (ready_in),
   .ad_out    (ad_out),
   .ad_oe     (ad_oe),
   .ale       (ale),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .den_n     (den_n),
   .dtr       (dtr),
   .done      (done),
   .rdata     (rdata)
);

// File: tb/mux_bus_seq_test.sv
`timescale 1ns/1ps
module mux_bus_seq_test;

   localparam int AW = 12;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic          req_io = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          ready_in = 1'b0;
   logic [AW-1:0] ad_out;
   logic          ad_oe;
   logic [DW-1:0] ad_in = '0;
   logic          ale, rd_n, wr_n, den_n, dtr, mio, done;
   logic [DW-1:0] rdata;

   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] last_rd = '0;

   always #2.5 clk = ~clk;

   mux_bus_seq #(.ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_io(req_io), .req_addr(req_addr),
      .req_wdata(req_wdata), .ready_in(ready_in), .ad_out(ad_out),
      .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
      .den_n(den_n), .dtr(dtr), .mio(mio), .done(done), .rdata(rdata)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
      end
   endtask

   function automatic logic [4:0] ctl_word();
      return {ale, rd_n, wr_n, den_n, done};
   endfunction

   task automatic chk_idle(input string tag);
      chk(ctl_word() == 5'b01110 && !ad_oe && !dtr && !mio && req_ready,
          tag, {ctl_word(), ad_oe, dtr, mio, req_ready}, {5'b01110, 4'b0001});
      chk(rdata == last_rd, "R6 rdata hold", rdata, last_rd);
   endtask

   // starts at a negedge where the sequencer is idle or in T4, ends at the T4 negedge
   task automatic bus_cycle(input bit wr, input bit io, input int k,
                            input int nwait, input bit poke);
      logic [AW-1:0] a;
      logic [DW-1:0] wd, rv;
      logic [AW-1:0] wext;
      logic [4:0]    act_ctl;
      a    = AW'((k * 37 + 5) % (1 << AW));
      wd   = DW'(k * 11 + 3);
      rv   = DW'(k * 29 + 7);
      wext = {{(AW-DW){1'b0}}, wd};
      act_ctl = {1'b0, wr, !wr, 1'b0, 1'b0};
      chk(req_ready == 1'b1, "R9 ready before accept", req_ready, 1);
      req_valid = 1'b1; req_write = wr; req_io = io; req_addr = a;
      req_wdata = wd; ready_in = k[0]; ad_in = ~rv;
      @(negedge clk);
      req_valid = 1'b0; req_write = !wr; req_io = !io; req_addr = ~a;
      // T1
      chk(ale && ad_oe && ad_out == a, "R2 T1 addr", {ale, ad_oe, 12'(ad_out)},
          {2'b11, 12'(a)});
      chk({rd_n, wr_n, den_n, done} == 4'b1110, "R2 T1 strobes",
          {rd_n, wr_n, den_n, done}, 4'b1110);
      chk(dtr == wr && mio == io, "R8 T1 dir/space", {dtr, mio}, {wr, io});
      chk(req_ready == 1'b0, "R9 busy in T1", req_ready, 0);
      ready_in = (nwait == 0);
      @(negedge clk);
      // T2
      if (poke) begin
         req_valid = 1'b1; req_addr = a ^ 12'hA5A;
         chk(req_ready == 1'b0, "R9 busy in T2", req_ready, 0);
      end
      chk(ctl_word() == act_ctl, "R3 T2 strobes", ctl_word(), act_ctl);
      chk(ad_oe == wr, "R3 T2 bus enable", ad_oe, wr);
      if (wr) chk(ad_out == wext, "R3 T2 write data", ad_out, wext);
      for (int w = 0; w < nwait; w++) begin
         @(negedge clk);
         req_valid = 1'b0;
         chk(ctl_word() == act_ctl && ad_oe == wr && dtr == wr && mio == io,
             "R5 wait freeze", {ctl_word(), ad_oe, dtr, mio},
             {act_ctl, wr, wr, io});
         if (wr) chk(ad_out == wext, "R5 wait data", ad_out, wext);
         ready_in = (w == nwait - 1);
      end
      @(negedge clk);
      req_valid = 1'b0;
      // T3
      chk(ctl_word() == act_ctl, "R4 T3 strobes", ctl_word(), act_ctl);
      ready_in = 1'b0; ad_in = rv;
      @(negedge clk);
      // T4
      chk({ale, rd_n, wr_n, den_n, done} == 5'b01111, "R7 T4 release",
          ctl_word(), 5'b01111);
      chk(ad_oe == wr, "R7 T4 bus enable", ad_oe, wr);
      if (wr) chk(ad_out == wext, "R7 T4 data held", ad_out, wext);
      chk(dtr == wr && mio == io, "R8 T4 dir/space", {dtr, mio}, {wr, io});
      chk(req_ready == 1'b1, "R9 ready in T4", req_ready, 1);
      if (!wr) last_rd = rv;
      chk(rdata == last_rd, "R6 rdata in T4", rdata, last_rd);
      ad_in = ~rv;
   endtask

   task automatic to_idle();
      @(negedge clk);
      chk_idle("R7 single done / R1 idle");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_idle("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1 after reset");
      // sweep direction, space and wait count
      for (int c = 0; c < 16; c++) begin
         bus_cycle(c[0], c[1], c, c / 4, 1'b0);
         to_idle();
      end
      // ignored request raised mid-cycle
      bus_cycle(1'b0, 1'b0, 40, 1, 1'b1);
      to_idle();
      chk(ale == 1'b0, "R9 poke ignored", ale, 0);
      // back-to-back chain
      bus_cycle(1'b0, 1'b1, 50, 0, 1'b0);
      bus_cycle(1'b1, 1'b0, 51, 2, 1'b0);
      bus_cycle(1'b0, 1'b0, 52, 5, 1'b0);
      to_idle();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule